// File: doc/BRIEF.md
# Grouped-Opcode Arithmetic and Logic Unit

A purely combinational 8-bit datapath unit with a two-level opcode. A 2-bit group selector picks one of four function groups (arithmetic, bit movement, magnitude/equality compare, bitwise logic). A 2-bit mode field then picks one operation inside that group. Every group computes in parallel, and a selector-driven multiplexer passes one group's word to the result port.

Operands `a_i` and `b_i` are unsigned words of `W` bits, with a default of 8. The result appears in the same cycle as the inputs. It carries no flags and no carry, and it holds no state. Every selector/mode combination gives a defined word. The one unused arithmetic mode gives zero.

Top module: `grouped_alu`

## Requirements
- R1: Selector encoding is 00 arithmetic, 01 bit movement, 10 compare, 11 bitwise logic. Changing only the selector with fixed operands and mode moves the result to the chosen group's value.
- R2: Arithmetic mode 00 gives (a + b) mod 2^W. For example, 0xFF + 0x02 = 0x01.
- R3: Arithmetic mode 01 gives (a - b) mod 2^W by adding the inverted B plus one. For example, 7 - 5 = 2 and 0 - 1 = 0xFF.
- R4: Arithmetic mode 10 gives the low W bits of the unsigned product. For example, 5 * 3 = 15, 0x10 * 0x10 = 0x00 and 0xFF * 0xFF = 0x01.
- R5: Arithmetic mode 11 gives zero whatever the operands are.
- R6: Bit-movement modes 00 and 01 rotate A right or left by one position. B has no effect. For example, rotate left of 0xAA gives 0x55 and rotate right of 0x01 gives 0x80.
- R7: Bit-movement modes 10 and 11 shift A right or left by one position and fill the vacated bit with 0. B has no effect. For example, 0x81 gives 0x40 shifted right and 0x02 shifted left.
- R8: Compare modes 00 (A > B) and 01 (A < B) are unsigned. The 1-bit outcome sits in bit 0 and bits W-1..1 are 0. For example, 0x80 > 0x7F gives 0x01.
- R9: Compare mode 10 (A == B) and mode 11 (A != B) give 0x01 when true and 0x00 when false. For example, 5 == 5 gives 1.
- R10: Logic modes are 00 AND, 01 OR, 10 NOT A and 11 XOR. In mode 10, B has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 2 | Function group selector |
| mode_i | input | 2 | Operation within the selected group |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| res_o | output | W | Result word of the selected operation |

## Verification
The checks sample the result whenever it settles after an input change. They take for granted that the inputs are fully driven 0/1 words and never unknown. They also assume the selector and mode do not change halfway through an evaluation. The bench gives every input a defined value from time zero. It changes all inputs together at one clock edge and reads the output at the opposite edge. Because of this, each check sees one stable set of operands only.

// File: rtl/grouped_alu_pkg.sv
package grouped_alu_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_MOVE  = 2'b01,
    GRP_CMP   = 2'b10,
    GRP_LOGIC = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    AR_ADD = 2'b00,
    AR_SUB = 2'b01,
    AR_MUL = 2'b10,
    AR_NOP = 2'b11
  } arith_e;

  typedef enum logic [1:0] {
    MV_ROR = 2'b00,
    MV_ROL = 2'b01,
    MV_SHR = 2'b10,
    MV_SHL = 2'b11
  } move_e;

  typedef enum logic [1:0] {
    CM_GT = 2'b00,
    CM_LT = 2'b01,
    CM_EQ = 2'b10,
    CM_NE = 2'b11
  } cmp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_NOT = 2'b10,
    LG_XOR = 2'b11
  } logic_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import grouped_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic         sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W-1:0] prod;

  assign sub   = mode_i[0];
  assign b_eff = sub ? ~b_i : b_i;
  assign sum   = a_i + b_eff + W'(sub);
  assign prod  = W'(a_i * b_i);

  always_comb begin
    unique case (arith_e'(mode_i))
      AR_ADD, AR_SUB: res_o = sum;
      AR_MUL:         res_o = prod;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_move.sv
module alu_move
  import grouped_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (move_e'(mode_i))
      MV_ROR:  res_o = {a_i[0], a_i[W-1:1]};
      MV_ROL:  res_o = {a_i[W-2:0], a_i[W-1]};
      MV_SHR:  res_o = {1'b0, a_i[W-1:1]};
      default: res_o = {a_i[W-2:0], 1'b0};
    endcase
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
  import grouped_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic hit;

  always_comb begin
    unique case (cmp_e'(mode_i))
      CM_GT:   hit = a_i > b_i;
      CM_LT:   hit = a_i < b_i;
      CM_EQ:   hit = a_i == b_i;
      default: hit = a_i != b_i;
    endcase
  end

  assign res_o = {{(W-1){1'b0}}, hit};
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import grouped_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (logic_e'(mode_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_NOT:  res_o = ~a_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/grouped_alu.sv
module grouped_alu
  import grouped_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int NGRP = 4;

  logic [W-1:0] grp_res [NGRP];

  alu_arith #(.W(W)) u_arith (.mode_i(mode_i), .a_i(a_i), .b_i(b_i), .res_o(grp_res[GRP_ARITH]));
  alu_move  #(.W(W)) u_move  (.mode_i(mode_i), .a_i(a_i),            .res_o(grp_res[GRP_MOVE]));
  alu_cmp   #(.W(W)) u_cmp   (.mode_i(mode_i), .a_i(a_i), .b_i(b_i), .res_o(grp_res[GRP_CMP]));
  alu_logic #(.W(W)) u_logic (.mode_i(mode_i), .a_i(a_i), .b_i(b_i), .res_o(grp_res[GRP_LOGIC]));

  assign res_o = grp_res[sel_i];
endmodule

// File: rtl/grouped_alu_chk.sv
module grouped_alu_chk #(
  parameter int W = 8
) (
  input logic [1:0]   sel_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o
);
  always_comb begin
    assert_add_inverse_R2: assert (!(sel_i == 2'b00 && mode_i == 2'b00) || W'(res_o - b_i) == a_i);
    assert_sub_inverse_R3: assert (!(sel_i == 2'b00 && mode_i == 2'b01) || W'(res_o + b_i) == a_i);
    assert_arith_idle_R5:  assert (!(sel_i == 2'b00 && mode_i == 2'b11) || res_o == '0);
    assert_rot_keeps_ones_R6: assert (!(sel_i == 2'b01 && !mode_i[1]) || $countones(res_o) == $countones(a_i));
    assert_shl_fill_R7: assert (!(sel_i == 2'b01 && mode_i == 2'b11) || (res_o[0] == 1'b0 && res_o[W-1:1] == a_i[W-2:0]));
    assert_shr_fill_R7: assert (!(sel_i == 2'b01 && mode_i == 2'b10) || (res_o[W-1] == 1'b0 && res_o[W-2:0] == a_i[W-1:1]));
    assert_cmp_zext_R8: assert (!(sel_i == 2'b10) || res_o[W-1:1] == '0);
    assert_eq_R9: assert (!(sel_i == 2'b10 && mode_i == 2'b10) || res_o[0] == (a_i == b_i));
    assert_ne_R9: assert (!(sel_i == 2'b10 && mode_i == 2'b11) || res_o[0] == (a_i != b_i));
    assert_not_R10: assert (!(sel_i == 2'b11 && mode_i == 2'b10) || (res_o ^ a_i) == '1);
  end
endmodule

bind grouped_alu grouped_alu_chk #(.W(W)) u_chk (
  .sel_i(sel_i), .mode_i(mode_i), .a_i(a_i), .b_i(b_i), .res_o(res_o)
);

// File: tb/grouped_alu_test.sv
module grouped_alu_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] sel = '0;
  logic [1:0] mode = '0;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic [7:0] res;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  grouped_alu #(.W(8)) uut (.sel_i(sel), .mode_i(mode), .a_i(a), .b_i(b), .res_o(res));

  function automatic logic [7:0] model(input logic [1:0] s, input logic [1:0] m,
                                       input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc;
    case (s)
      2'd0: begin
        case (m)
          2'd0: return x + y;
          2'd1: return x - y;
          2'd2: begin
            acc = 8'h00;
            for (int i = 0; i < 8; i++) if (y[i]) acc = acc + (x << i);
            return acc;
          end
          default: return 8'h00;
        endcase
      end
      2'd1: begin
        case (m)
          2'd0: return (x >> 1) | (x << 7);
          2'd1: return (x << 1) | (x >> 7);
          2'd2: return x >> 1;
          default: return x << 1;
        endcase
      end
      2'd2: begin
        case (m)
          2'd0: return (x > y) ? 8'd1 : 8'd0;
          2'd1: return (x < y) ? 8'd1 : 8'd0;
          2'd2: return (x == y) ? 8'd1 : 8'd0;
          default: return (x != y) ? 8'd1 : 8'd0;
        endcase
      end
      default: begin
        case (m)
          2'd0: return x & y;
          2'd1: return x | y;
          2'd2: return ~x;
          default: return x ^ y;
        endcase
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] s, input logic [1:0] m);
    case ({s, m})
      4'b0000: return "R2";
      4'b0001: return "R3";
      4'b0010: return "R4";
      4'b0011: return "R5";
      4'b0100, 4'b0101: return "R6";
      4'b0110, 4'b0111: return "R7";
      4'b1000, 4'b1001: return "R8";
      4'b1010, 4'b1011: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [1:0] s, input logic [1:0] m, input logic [7:0] x,
                       input logic [7:0] y, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    sel = s; mode = m; a = x; b = y;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: outputs settle after posedge drive, compared at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (res !== it.exp) begin
          bad++;
          $display("FAIL %s: sel=%0d mode=%0d a=%h b=%h actual=%h expected=%h",
                   it.tag, sel, mode, a, b, res, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (res !== 8'h00) begin
      bad++;
      $display("FAIL R2 reset-state add of zeros: actual=%h expected=00", res);
    end
    rst_ni = 1'b1;

    // directed cases
    drive(2'd0, 2'd0, 8'hFF, 8'h02, 8'h01, "R2");
    drive(2'd0, 2'd1, 8'd7,  8'd5,  8'd2,  "R3");
    drive(2'd0, 2'd1, 8'h00, 8'h01, 8'hFF, "R3");
    drive(2'd0, 2'd2, 8'd5,  8'd3,  8'd15, "R4");
    drive(2'd0, 2'd2, 8'h10, 8'h10, 8'h00, "R4");
    drive(2'd0, 2'd2, 8'hFF, 8'hFF, 8'h01, "R4");
    drive(2'd0, 2'd3, 8'hA5, 8'h3C, 8'h00, "R5");
    drive(2'd1, 2'd1, 8'hAA, 8'h00, 8'h55, "R6");
    drive(2'd1, 2'd0, 8'h01, 8'hFF, 8'h80, "R6 B ignored");
    drive(2'd1, 2'd2, 8'h81, 8'h5A, 8'h40, "R7 B ignored");
    drive(2'd1, 2'd3, 8'h81, 8'h00, 8'h02, "R7");
    drive(2'd2, 2'd0, 8'h80, 8'h7F, 8'h01, "R8 unsigned");
    drive(2'd2, 2'd1, 8'h80, 8'h7F, 8'h00, "R8 unsigned");
    drive(2'd2, 2'd2, 8'd5,  8'd5,  8'h01, "R9");
    drive(2'd2, 2'd3, 8'd5,  8'd5,  8'h00, "R9");
    drive(2'd3, 2'd3, 8'hF0, 8'h3C, 8'hCC, "R10");
    drive(2'd3, 2'd2, 8'h0F, 8'hAA, 8'hF0, "R10 B ignored");
    // R1: same mode and operands, only selector changes
    drive(2'd0, 2'd0, 8'h0C, 8'h0A, 8'h16, "R1");
    drive(2'd1, 2'd0, 8'h0C, 8'h0A, 8'h06, "R1");
    drive(2'd2, 2'd0, 8'h0C, 8'h0A, 8'h01, "R1");
    drive(2'd3, 2'd0, 8'h0C, 8'h0A, 8'h08, "R1");

    // sweep every selector/mode over a set of operand pairs
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 5; p++) begin
          logic [7:0] x, y;
          x = 8'(p * 53 + s * 7 + 1);
          y = 8'(p * 91 + m * 13);
          if (p == 4) y = x;
          drive(2'(s), 2'(m), x, y, model(2'(s), 2'(m), x, y), req_of(2'(s), 2'(m)));
        end
      end
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule